// File: doc/BRIEF.md
# Branch, Skip and Call Sequencer

This unit decides where a small 16-bit-instruction microcontroller fetches next. Each accepted instruction word arrives with the current program counter, the status byte and the contents of the register that a bit-test names. The unit returns the following program counter one cycle later. For relative call and return it instead runs a two-cycle stack transfer on a byte-wide memory port and keeps its own stack pointer.

The supported flow changes are: a conditional branch on one status bit with a 7-bit signed offset, a relative jump and a relative call with a 12-bit signed offset, a return, and a skip over one instruction that depends on one bit of a register. Every other word, the all-zero no-op included, simply advances by one. The memory port is read combinationally: read data belongs to the address shown in the same cycle. A write takes effect at the clock edge that closes a cycle with the write strobe high.

Top module: `flow_ctrl_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pc_vld`, `skip`, `busy`, `mem_we` and `mem_re` are 0, and `sp` equals `SP_INIT`.
- R2: For a word whose bits [15:11] are 11110, bit 10 is the polarity p, bits [9:3] are the two's-complement offset k and bits [2:0] select a status bit. The branch is taken when `sreg[sel]` differs from p. Taken gives `pc + 1 + k`; not taken gives `pc + 1`. The result appears with `pc_vld` one cycle after acceptance.
- R3: A word with bits [15:12] = 1100 is a jump to `pc + 1 + j`, where j is bits [11:0] read as two's complement (a raw value above 2047 means raw - 4096). The result appears one cycle after acceptance.
- R4: For a word with bits [15:10] = 111111 and bit 3 = 0, bit 9 is the polarity p and bits [2:0] select a bit of `test_reg`. When that bit equals p, the next PC is `pc + 2` and `skip` is 1. Otherwise the next PC is `pc + 1` and `skip` is 0.
- R5: Any other word, including 0x0000 and the skip pattern with bit 3 set, gives `pc + 1` with `skip` 0, one cycle after acceptance.
- R6: A word with bits [15:12] = 1101 is a call. For two cycles `busy` is 1 and `mem_we` is 1. The first cycle writes `pc[7:0]` at address `sp`; the second writes `pc[15:8]` at `sp - 1`. In the next cycle `pc_vld` is 1 with `pc + 1 + j`, and `sp` has dropped by 2.
- R7: The word 0x9508 is a return. For two cycles `busy` and `mem_re` are 1. The first cycle reads the high byte at `sp + 1`; the second reads the low byte at `sp + 2`. In the next cycle `pc_vld` is 1 with that word plus 1, and `sp` has risen by 2.
- R8: All program-counter arithmetic wraps modulo 2^16.
- R9: An issue made while `busy` is 1 is ignored. It creates no `pc_vld` pulse and does not alter the result or the stack pointer of the transfer in progress.
- R10: `mem_we` and `mem_re` are never high together. Either one is high only while `busy` is high. `pc_vld` is never high while `busy` is high, and `skip` is high only together with `pc_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the presented instruction |
| sreg | input | 8 | Status bits |
| test_reg | input | 8 | Contents of the register named by a skip word |
| busy | output | 1 | Stack transfer in progress; issues are ignored |
| pc_vld | output | 1 | `pc_next` holds a new value this cycle |
| pc_next | output | 16 | Next program counter |
| skip | output | 1 | The next instruction is being stepped over |
| sp | output | 16 | Current stack pointer |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Stack byte read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read at `mem_addr`, same cycle |

## Verification
Some properties are checked on every cycle. Busy lasts exactly two cycles. Push addresses step down by one and pop addresses step up by one. The stack pointer moves only at the end of a transfer, by exactly two in the right direction. Strobes are exclusive, and the result strobe never overlaps busy. Target values cannot be shown that way and need the bench's scenarios: offsets at both ends of their ranges, wrap-around past 0xFFFF, every branch and skip polarity, the byte order left in memory by a call, and the return address rebuilt from planted bytes.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_BRANCH = 3'd1,
    K_JUMP   = 3'd2,
    K_CALL   = 3'd3,
    K_RET    = 3'd4,
    K_SKIP   = 3'd5
  } kind_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } stk_state_t;

  localparam logic [15:0] RET_WORD = 16'h9508;
  localparam int          BR_OFF_W = 7;
  localparam int          JMP_OFF_W = 12;

endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
  import fcu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic [15:0]   instr,
  output kind_t         kind,
  output logic          pol,
  output logic [2:0]    sel,
  output logic [PC_W-1:0] offset
);

  logic [PC_W-1:0] br_off;
  logic [PC_W-1:0] jmp_off;

  // sign-extend both offset fields to the PC width
  assign br_off  = {{(PC_W-BR_OFF_W){instr[9]}}, instr[9:3]};
  assign jmp_off = {{(PC_W-JMP_OFF_W){instr[11]}}, instr[11:0]};
  assign sel     = instr[2:0];

  always_comb begin
    kind = K_PLAIN;
    if (instr == RET_WORD)
      kind = K_RET;
    else if (instr[15:11] == 5'b11110)
      kind = K_BRANCH;
    else if (instr[15:12] == 4'hC)
      kind = K_JUMP;
    else if (instr[15:12] == 4'hD)
      kind = K_CALL;
    else if (instr[15:10] == 6'b111111 && !instr[3])
      kind = K_SKIP;
  end

  always_comb begin
    pol    = 1'b0;
    offset = '0;
    case (kind)
      K_BRANCH: begin
        pol    = instr[10];
        offset = br_off;
      end
      K_JUMP, K_CALL: offset = jmp_off;
      K_SKIP:         pol    = instr[9];
      default: ;
    endcase
  end

endmodule

// File: rtl/fcu_target.sv
module fcu_target
  import fcu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  kind_t           kind,
  input  logic            pol,
  input  logic [2:0]      sel,
  input  logic [PC_W-1:0] offset,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      sreg,
  input  logic [7:0]      test_reg,
  output logic [PC_W-1:0] target,
  output logic            skip_hit
);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_pc;
  logic            flag_bit;
  logic            test_bit;

  assign seq_pc   = pc + PC_W'(1);
  assign rel_pc   = seq_pc + offset;
  assign flag_bit = sreg[sel];
  assign test_bit = test_reg[sel];

  always_comb begin
    target   = seq_pc;
    skip_hit = 1'b0;
    case (kind)
      K_BRANCH: if (flag_bit != pol) target = rel_pc;
      K_JUMP, K_CALL: target = rel_pc;
      K_SKIP: if (test_bit == pol) begin
        target   = pc + PC_W'(2);
        skip_hit = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fcu_stack.sv
module fcu_stack
  import fcu_pkg::*;
#(
  parameter int          PC_W    = 16,
  parameter int          SP_W    = 16,
  parameter int          BYTE_W  = 8,
  parameter logic [SP_W-1:0] SP_INIT = 16'h03FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_call,
  input  logic              start_ret,
  input  logic [PC_W-1:0]   push_word,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              last_call,
  output logic              last_ret,
  output logic [PC_W-1:0]   pop_word,
  output logic [SP_W-1:0]   sp,
  output logic              mem_we,
  output logic              mem_re,
  output logic [SP_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);

  stk_state_t        state;
  logic              is_call;
  logic [PC_W-1:0]   hold;
  logic [BYTE_W-1:0] hi_byte;

  assign busy      = (state != ST_IDLE);
  assign last_call = (state == ST_SECOND) && is_call;
  assign last_ret  = (state == ST_SECOND) && !is_call;
  assign pop_word  = {hi_byte, mem_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_call   <= 1'b0;
      hold      <= '0;
      hi_byte   <= '0;
      sp        <= SP_INIT;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_call) begin
            state     <= ST_FIRST;
            is_call   <= 1'b1;
            hold      <= push_word;
            mem_we    <= 1'b1;
            mem_addr  <= sp;
            mem_wdata <= push_word[BYTE_W-1:0];
          end else if (start_ret) begin
            state    <= ST_FIRST;
            is_call  <= 1'b0;
            mem_re   <= 1'b1;
            mem_addr <= sp + SP_W'(1);
          end
        end
        ST_FIRST: begin
          state <= ST_SECOND;
          if (is_call) begin
            mem_addr  <= sp - SP_W'(1);
            mem_wdata <= hold[PC_W-1:BYTE_W];
          end else begin
            hi_byte  <= mem_rdata;
            mem_addr <= sp + SP_W'(2);
          end
        end
        default: begin
          state  <= ST_IDLE;
          mem_we <= 1'b0;
          mem_re <= 1'b0;
          if (is_call) sp <= sp - SP_W'(2);
          else         sp <= sp + SP_W'(2);
        end
      endcase
    end
  end

endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import fcu_pkg::*;
#(
  parameter int          PC_W    = 16,
  parameter int          SP_W    = 16,
  parameter logic [SP_W-1:0] SP_INIT = 16'h03FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [15:0]     instr,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      sreg,
  input  logic [7:0]      test_reg,
  output logic            busy,
  output logic            pc_vld,
  output logic [PC_W-1:0] pc_next,
  output logic            skip,
  output logic [SP_W-1:0] sp,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);

  localparam int BYTE_W = 8;

  kind_t           kind;
  logic            pol;
  logic [2:0]      sel;
  logic [PC_W-1:0] offset;
  logic [PC_W-1:0] target;
  logic            skip_hit;
  logic            accept;
  logic            last_call;
  logic            last_ret;
  logic [PC_W-1:0] pop_word;
  logic [PC_W-1:0] call_target;

  assign accept = issue_valid && !busy;

  fcu_decode #(.PC_W(PC_W)) u_dec (
    .instr  (instr),
    .kind   (kind),
    .pol    (pol),
    .sel    (sel),
    .offset (offset)
  );

  fcu_target #(.PC_W(PC_W)) u_tgt (
    .kind     (kind),
    .pol      (pol),
    .sel      (sel),
    .offset   (offset),
    .pc       (pc),
    .sreg     (sreg),
    .test_reg (test_reg),
    .target   (target),
    .skip_hit (skip_hit)
  );

  fcu_stack #(
    .PC_W    (PC_W),
    .SP_W    (SP_W),
    .BYTE_W  (BYTE_W),
    .SP_INIT (SP_INIT)
  ) u_stk (
    .clk        (clk),
    .rst        (rst),
    .start_call (accept && kind == K_CALL),
    .start_ret  (accept && kind == K_RET),
    .push_word  (pc),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .last_call  (last_call),
    .last_ret   (last_ret),
    .pop_word   (pop_word),
    .sp         (sp),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_vld      <= 1'b0;
      pc_next     <= '0;
      skip        <= 1'b0;
      call_target <= '0;
    end else begin
      pc_vld <= 1'b0;
      skip   <= 1'b0;
      if (accept) begin
        if (kind == K_CALL) begin
          call_target <= target;
        end else if (kind != K_RET) begin
          pc_vld  <= 1'b1;
          pc_next <= target;
          skip    <= skip_hit;
        end
      end
      if (last_call) begin
        pc_vld  <= 1'b1;
        pc_next <= call_target;
      end else if (last_ret) begin
        pc_vld  <= 1'b1;
        pc_next <= pop_word + PC_W'(1);
      end
    end
  end

endmodule

// File: rtl/fcu_chk.sv
module fcu_chk #(
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            pc_vld,
  input logic            skip,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr,
  input logic [SP_W-1:0] sp
);

  p_busy_two_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);

  p_vld_idle_r10: assert property (@(posedge clk) disable iff (rst)
    pc_vld |-> !busy);

  p_skip_vld_r4: assert property (@(posedge clk) disable iff (rst)
    skip |-> pc_vld);

  p_push_down_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - SP_W'(1));

  p_pop_up_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) + SP_W'(1));

  p_sp_call_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(mem_we)) |-> sp == $past(sp) - SP_W'(2));

  p_sp_ret_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(mem_re)) |-> sp == $past(sp) + SP_W'(2));

  p_sp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(sp));

endmodule

bind flow_ctrl_unit fcu_chk #(.SP_W(SP_W)) u_fcu_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .pc_vld   (pc_vld),
  .skip     (skip),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp       (sp)
);

// File: tb/flow_ctrl_unit_test.sv
module flow_ctrl_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc = '0;
  logic [7:0]  sreg = '0;
  logic [7:0]  test_reg = '0;
  logic        busy, pc_vld, skip, mem_we, mem_re;
  logic [15:0] pc_next, sp, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  ram [0:1023];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  flow_ctrl_unit uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .pc(pc), .sreg(sreg), .test_reg(test_reg), .busy(busy),
    .pc_vld(pc_vld), .pc_next(pc_next), .skip(skip), .sp(sp),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = ram[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;

  function automatic logic [15:0] enc_br(bit p, logic [6:0] k, logic [2:0] b);
    return {5'b11110, p, k, b};
  endfunction
  function automatic logic [15:0] enc_skp(bit p, logic [4:0] d, logic [2:0] b);
    return {6'b111111, p, d, 1'b0, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle flow change: result one cycle after acceptance
  task automatic t_simple(string req, logic [15:0] w, logic [15:0] p,
                          logic [7:0] s, logic [7:0] t,
                          logic [15:0] exp_pc, bit exp_skip);
    @(negedge clk);
    instr = w; pc = p; sreg = s; test_reg = t; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    chk({req, " vld"}, {31'd0, pc_vld}, 32'd1);
    chk({req, " pc"}, {16'd0, pc_next}, {16'd0, exp_pc});
    chk({req, " skip"}, {31'd0, skip}, {31'd0, exp_skip});
  endtask

  // two-cycle stack transfer; optionally issue a jump while busy (R9)
  task automatic t_stack(string req, logic [15:0] w, logic [15:0] p,
                         logic [15:0] exp_pc, logic [15:0] exp_sp, bit intrude);
    @(negedge clk);
    instr = w; pc = p; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = intrude;
    if (intrude) begin instr = 16'hC010; pc = 16'h5000; end
    chk({req, " busy1"}, {31'd0, busy}, 32'd1);
    chk({req, " vld low"}, {31'd0, pc_vld}, 32'd0);
    @(negedge clk);
    issue_valid = 1'b0;
    chk({req, " busy2"}, {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk({req, " done"}, {30'd0, busy, pc_vld}, 32'd1);
    chk({req, " pc"}, {16'd0, pc_next}, {16'd0, exp_pc});
    chk({req, " sp"}, {16'd0, sp}, {16'd0, exp_sp});
    @(negedge clk);
    chk({req, " no extra"}, {31'd0, pc_vld}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 vld", {31'd0, pc_vld}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 strobes", {29'd0, skip, mem_we, mem_re}, 32'd0);
    chk("R1 sp", {16'd0, sp}, 32'h03FF);
  endtask

  task automatic t_branches();
    t_simple("R2 fwd taken", enc_br(1'b0, 7'd5, 3'd1), 16'h0100, 8'h02, 8'h00, 16'h0106, 1'b0);
    t_simple("R2 back taken", enc_br(1'b1, 7'd125, 3'd0), 16'h0100, 8'h00, 8'h00, 16'h00FE, 1'b0);
    t_simple("R2 not taken", enc_br(1'b0, 7'd5, 3'd1), 16'h0100, 8'h00, 8'h00, 16'h0101, 1'b0);
    t_simple("R2 max fwd", enc_br(1'b1, 7'd63, 3'd7), 16'h0200, 8'h7F, 8'h00, 16'h0240, 1'b0);
  endtask

  task automatic t_jumps();
    t_simple("R3 max fwd", 16'hC7FF, 16'h1000, 8'h00, 8'h00, 16'h1800, 1'b0);
    t_simple("R3 max back", 16'hC800, 16'h0800, 8'h00, 8'h00, 16'h0001, 1'b0);
    t_simple("R8 wrap low", 16'hCFFC, 16'h0001, 8'h00, 8'h00, 16'hFFFE, 1'b0);
    t_simple("R8 wrap high", 16'hC000, 16'hFFFF, 8'h00, 8'h00, 16'h0000, 1'b0);
  endtask

  task automatic t_skips();
    t_simple("R4 skip set", enc_skp(1'b1, 5'd3, 3'd3), 16'h0300, 8'h00, 8'h08, 16'h0302, 1'b1);
    t_simple("R4 no skip", enc_skp(1'b0, 5'd3, 3'd3), 16'h0300, 8'h00, 8'h08, 16'h0301, 1'b0);
    t_simple("R4 skip clear", enc_skp(1'b0, 5'd9, 3'd6), 16'hFFFF, 8'h00, 8'hBF, 16'h0001, 1'b1);
  endtask

  task automatic t_plain();
    t_simple("R5 nop", 16'h0000, 16'h0420, 8'hFF, 8'hFF, 16'h0421, 1'b0);
    t_simple("R5 bit3 set", 16'hFE08, 16'h0420, 8'h00, 8'hFF, 16'h0421, 1'b0);
  endtask

  task automatic t_stack_ops();
    ram[0] = 8'hFF; ram[1] = 8'hFF;
    t_stack("R7 planted ret", 16'h9508, 16'h0700, 16'h0000, 16'h0401, 1'b0);
    t_stack("R6 call", 16'hD010, 16'h1234, 16'h1245, 16'h03FF, 1'b1);
    chk("R6 low byte at sp", {24'd0, ram[1]}, 32'h34);
    chk("R6 high byte at sp-1", {24'd0, ram[0]}, 32'h12);
    t_stack("R7 ret", 16'h9508, 16'h1245, 16'h1235, 16'h0401, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_branches();
    t_jumps();
    t_skips();
    t_plain();
    t_stack_ops();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule